// File: doc/BRIEF.md
# Parity-Protected Translation Table with Error Injection

This block stores a 64-entry translation table. Every entry is a data word split into four equal-width protected groups. Each group keeps one parity bit. A write computes even parity for each group. A 4-bit injection control register can invert the parity bit of chosen groups, so that software can plant a deliberate error and exercise its machine-check handler. Three access paths share one lookup pipeline, and each checks the parity of the entry it touches:

- a software-style read;
- a search, whose tag compare happens outside this block and hands in the candidate index;
- a refill that feeds the instruction or data micro-TLB.

When a check fails, the block sets sticky status bits. Two inputs decide what happens next: the local machine-check enable bit and the recoverability enable input. The block either suppresses the result and raises a one-cycle machine-check request, or it lets a read complete with its raw parity and records the error as imprecise.

The controller is a three-state machine:

- **IDLE**: `op_ready` is high. A request is accepted when `op_valid` is high. Transition IDLE→LOOKUP on accept; otherwise IDLE→IDLE.
- **LOOKUP**: the registered entry is on the result outputs and the check runs. Transition LOOKUP→TRAP on a parity error while machine-check enable is 1. Otherwise LOOKUP→IDLE.
- **TRAP**: `mck_req` is high for one cycle. Transition TRAP→IDLE always.

Top module: `tlbpar_array`

## Requirements
- R1: After reset the block is in this state. `status` is 0 and every entry is invalid. The injection control is 0 and `me` is 0. `mck_req`, `flush` and `res_valid` are 0, and `op_ready` is 1.
- R2: A write with injection control 0 stores even parity for each group. Group g is data bits [8g+7:8g], and parity bit `res_par[g]` belongs to it. The number of ones in the group and its parity bit is even. Reading such an entry on any path gives `res_err`=0 and leaves `status` unchanged.
- R3: The injection control is loaded by `inj_wr_en`. When injection bit g is 1 during a write, the parity bit of group g is inverted before storage, so that group holds odd parity. Injection bit 0 maps to the lowest group. Each inverted group is reported in status bit 3+g on every access path.
- R4: A read that finds a parity error while `me`=0 still completes. `res_valid`=1 and `res_err`=1, and the stored data and parity are returned. `mck_req` stays 0. Status bits 0 (summary), 1 (table error) and 2 (imprecise) are set, together with the failing group bits.
- R5: A read that finds a parity error while `me`=1 and `recov_en`=1 produces no result. `res_valid`=0 and `flush`=1. A machine-check request follows. Status bit 2 is not set.
- R6: A read that finds a parity error while `me`=1 and `recov_en`=0 completes with `res_err`=1. It also raises a machine-check request and sets status bit 2.
- R7: Taking a machine check has these effects. `mck_req` is high for exactly the cycle after the failing lookup. In that cycle `me` is 0. `save_pc` holds the failing operation's `op_pc`. `save_msr` holds `msr_in` with bit 0 replaced by the old enable value, which is 1. A `me_set` pulse sets `me` again.
- R8: A search (`op_kind`=1) or refill (`op_kind`=2 instruction, 3 data) that finds a parity error never completes: `res_valid`=0 and `flush`=1, so no micro-TLB is updated. With `me`=1 it traps and does not set status bit 2. With `me`=0 it does not trap and sets status bit 2.
- R9: An access to an invalid entry skips the parity check. It completes with `res_hit`=0, data 0 and parity 0, and `status` is unchanged. A read (`op_kind`=0) of a valid entry gives `res_hit`=1.
- R10: Status bits are sticky. A write with `st_clr_en` clears exactly the bits set in `st_clr_mask` and leaves the others unchanged.
- R11: A request accepted at a clock edge gives its result or flush in the following cycle. `op_ready` is 0 from acceptance until the controller returns to IDLE. That return comes one cycle after the result, or two cycles when a trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 32 | Entry word to write |
| inj_wr_en | input | 1 | Load the injection control |
| inj_val | input | 4 | New injection control, one bit per group |
| op_valid | input | 1 | Access request |
| op_kind | input | 2 | 0 read, 1 search, 2 instruction refill, 3 data refill |
| op_idx | input | 6 | Entry index to access |
| op_pc | input | 32 | Address of the requesting operation |
| msr_in | input | 8 | Current machine state; bit 0 is replaced by `me` when saved |
| recov_en | input | 1 | Recoverability enable for reads |
| me_set | input | 1 | Set the machine-check enable |
| st_clr_en | input | 1 | Write-one-to-clear strobe for status |
| st_clr_mask | input | 7 | Status bits to clear |
| op_ready | output | 1 | Controller idle, request can be accepted |
| res_valid | output | 1 | Access completes this cycle |
| res_hit | output | 1 | Accessed entry was valid |
| res_err | output | 1 | Completed access carries a parity error |
| res_data | output | 32 | Entry word |
| res_par | output | 4 | Stored parity bits |
| flush | output | 1 | Access suppressed by a parity error |
| mck_req | output | 1 | Machine-check interrupt request |
| me | output | 1 | Machine-check enable |
| save_pc | output | 32 | Saved operation address |
| save_msr | output | 8 | Saved machine state |
| status | output | 7 | Bit 0 summary, 1 table error, 2 imprecise, 6:3 failing groups |

## Verification
The bench plants odd parity in each group on its own and in pairs. It then drives the entry through every path under each combination of enable states, because a design that decodes the injection bits in the wrong order would report the wrong group bit. The bench looks for a refill or search that leaks a result while it flushes, which would be a corrupted micro-TLB. It also looks for a recoverable read that still completes, which would mean a register write that the handler cannot undo. Partial status clears, invalid entries and trap save values are compared every cycle against a behavioural model. A design that clears too much, checks parity on stale invalid words, or saves the wrong context shows up at once.

// File: rtl/tlbpar_pkg.sv
package tlbpar_pkg;
    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_SEARCH = 2'd1,
        OP_IFILL  = 2'd2,
        OP_DFILL  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_TRAP   = 2'd2
    } ctl_state_e;

    localparam int STB_SUMM = 0;
    localparam int STB_TLBE = 1;
    localparam int STB_IMPR = 2;
    localparam int STB_GRP  = 3;
endpackage

// File: rtl/tlbpar_pgen.sv
module tlbpar_pgen #(
    parameter int DW = 32,
    parameter int NG = 4
) (
    input  logic [DW-1:0] data,
    input  logic [NG-1:0] flip,
    output logic [NG-1:0] par
);
    localparam int GW = DW / NG;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign par[g] = (^data[g*GW +: GW]) ^ flip[g];
    end
endmodule

// File: rtl/tlbpar_store.sv
module tlbpar_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int NG    = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [NG-1:0] wr_par,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [NG-1:0] rd_par,
    output logic          rd_vld
);
    logic [DW+NG-1:0] mem [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= {wr_par, wr_data};
        if (rd_en) {rd_par, rd_data} <= mem[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= '0;
            rd_vld <= 1'b0;
        end else begin
            if (rd_en) rd_vld <= vld_q[rd_idx];
            if (wr_en) vld_q[wr_idx] <= 1'b1;
        end
    end

    // R2: a written entry becomes valid
    assert_write_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/tlbpar_ctrl.sv
module tlbpar_ctrl
    import tlbpar_pkg::*;
#(
    parameter int DW  = 32,
    parameter int NG  = 4,
    parameter int AW  = 32,
    parameter int MSW = 8,
    localparam int SW = STB_GRP + NG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [1:0]     op_kind,
    input  logic [AW-1:0]  op_pc,
    input  logic [MSW-1:0] msr_in,
    input  logic           recov_en,
    input  logic           me_set,
    input  logic           st_clr_en,
    input  logic [SW-1:0]  st_clr_mask,
    input  logic           ent_vld,
    input  logic [DW-1:0]  ent_data,
    input  logic [NG-1:0]  ent_par,
    input  logic [NG-1:0]  syndrome,
    output logic           op_ready,
    output logic           op_accept,
    output logic           res_valid,
    output logic           res_hit,
    output logic           res_err,
    output logic [DW-1:0]  res_data,
    output logic [NG-1:0]  res_par,
    output logic           flush,
    output logic           mck_req,
    output logic           me,
    output logic [AW-1:0]  save_pc,
    output logic [MSW-1:0] save_msr,
    output logic [SW-1:0]  status
);
    ctl_state_e    state_q, state_d;
    op_kind_e      kind_q;
    logic [AW-1:0] pc_q;
    logic          me_q;
    logic          in_lookup, err, is_read, suppress, take_trap, precise;
    logic [NG-1:0] grp_hit;

    assign in_lookup = (state_q == ST_LOOKUP);
    assign grp_hit   = ent_vld ? syndrome : '0;
    assign err       = in_lookup && (|grp_hit);
    assign is_read   = (kind_q == OP_READ);
    assign precise   = me_q && (!is_read || recov_en);
    assign suppress  = err && (!is_read || precise);
    assign take_trap = err && me_q;
    assign op_accept = op_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = take_trap ? ST_TRAP : ST_IDLE;
            ST_TRAP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        op_ready  = (state_q == ST_IDLE);
        res_valid = in_lookup && !suppress;
        res_hit   = res_valid && ent_vld;
        res_err   = res_valid && err;
        res_data  = res_hit ? ent_data : '0;
        res_par   = res_hit ? ent_par  : '0;
        flush     = suppress;
        mck_req   = (state_q == ST_TRAP);
        me        = me_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= OP_READ;
            pc_q     <= '0;
            me_q     <= 1'b0;
            save_pc  <= '0;
            save_msr <= '0;
            status   <= '0;
        end else begin
            if (op_accept) begin
                kind_q <= op_kind_e'(op_kind);
                pc_q   <= op_pc;
            end
            if (take_trap) begin
                me_q     <= 1'b0;
                save_pc  <= pc_q;
                save_msr <= {msr_in[MSW-1:1], me_q};
            end else if (me_set) begin
                me_q <= 1'b1;
            end
            if (err) begin
                status <= (st_clr_en ? (status & ~st_clr_mask) : status)
                        | SW'({grp_hit, !precise, 1'b1, 1'b1});
            end else if (st_clr_en) begin
                status <= status & ~st_clr_mask;
            end
        end
    end

    // R7: the enable bit is already clear while the request is raised
    assert_trap_clears_me_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP) |-> !me_q);
    // R7: one-cycle request
    assert_mck_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mck_req |=> !mck_req);
    // R8: searches and refills never complete with an error
    assert_no_bad_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && kind_q != OP_READ) |-> !res_err);
    // R10: a set error bit survives unless it is cleared
    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STB_TLBE] && !(st_clr_en && st_clr_mask[STB_TLBE])) |=> status[STB_TLBE]);
    // R11: after a result or flush the controller is idle or trapping
    assert_return_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || flush) |=> (op_ready || mck_req));
endmodule

// File: rtl/tlbpar_array.sv
module tlbpar_array
    import tlbpar_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int NG    = 4,
    parameter int AW    = 32,
    parameter int MSW   = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int SW   = STB_GRP + NG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic           inj_wr_en,
    input  logic [NG-1:0]  inj_val,
    input  logic           op_valid,
    input  logic [1:0]     op_kind,
    input  logic [IW-1:0]  op_idx,
    input  logic [AW-1:0]  op_pc,
    input  logic [MSW-1:0] msr_in,
    input  logic           recov_en,
    input  logic           me_set,
    input  logic           st_clr_en,
    input  logic [SW-1:0]  st_clr_mask,
    output logic           op_ready,
    output logic           res_valid,
    output logic           res_hit,
    output logic           res_err,
    output logic [DW-1:0]  res_data,
    output logic [NG-1:0]  res_par,
    output logic           flush,
    output logic           mck_req,
    output logic           me,
    output logic [AW-1:0]  save_pc,
    output logic [MSW-1:0] save_msr,
    output logic [SW-1:0]  status
);
    logic [NG-1:0] inj_q, wr_par, chk_par, ent_par, syndrome;
    logic [DW-1:0] ent_data;
    logic          ent_vld, op_accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         inj_q <= '0;
        else if (inj_wr_en) inj_q <= inj_val;
    end

    tlbpar_pgen #(.DW(DW), .NG(NG)) u_wgen (
        .data(wr_data), .flip(inj_q), .par(wr_par));

    tlbpar_store #(.DEPTH(DEPTH), .DW(DW), .NG(NG)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_par(wr_par),
        .rd_en(op_accept), .rd_idx(op_idx),
        .rd_data(ent_data), .rd_par(ent_par), .rd_vld(ent_vld));

    tlbpar_pgen #(.DW(DW), .NG(NG)) u_cgen (
        .data(ent_data), .flip('0), .par(chk_par));

    assign syndrome = chk_par ^ ent_par;

    tlbpar_ctrl #(.DW(DW), .NG(NG), .AW(AW), .MSW(MSW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_pc(op_pc), .msr_in(msr_in),
        .recov_en(recov_en), .me_set(me_set),
        .st_clr_en(st_clr_en), .st_clr_mask(st_clr_mask),
        .ent_vld(ent_vld), .ent_data(ent_data), .ent_par(ent_par), .syndrome(syndrome),
        .op_ready(op_ready), .op_accept(op_accept),
        .res_valid(res_valid), .res_hit(res_hit), .res_err(res_err),
        .res_data(res_data), .res_par(res_par), .flush(flush), .mck_req(mck_req),
        .me(me), .save_pc(save_pc), .save_msr(save_msr), .status(status));
endmodule

// File: tb/tlbpar_array_bench.sv
module tlbpar_array_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, inj_wr_en = 0, op_valid = 0, recov_en = 0, me_set = 0, st_clr_en = 0;
    logic [5:0]  wr_idx = 0, op_idx = 0;
    logic [31:0] wr_data = 0, op_pc = 0;
    logic [3:0]  inj_val = 0;
    logic [1:0]  op_kind = 0;
    logic [7:0]  msr_in = 0;
    logic [6:0]  st_clr_mask = 0;
    logic        op_ready, res_valid, res_hit, res_err, flush, mck_req, me;
    logic [31:0] res_data, save_pc;
    logic [3:0]  res_par;
    logic [7:0]  save_msr;
    logic [6:0]  status;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model
    logic [31:0] m_data [64];
    logic [3:0]  m_par  [64];
    bit          m_vld  [64];
    logic [3:0]  m_inj = 0;
    logic [6:0]  m_st = 0;
    bit          m_me = 0;

    always #10 clk = ~clk;

    tlbpar_array u_tlbpar_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .inj_wr_en(inj_wr_en), .inj_val(inj_val), .op_valid(op_valid), .op_kind(op_kind),
        .op_idx(op_idx), .op_pc(op_pc), .msr_in(msr_in), .recov_en(recov_en),
        .me_set(me_set), .st_clr_en(st_clr_en), .st_clr_mask(st_clr_mask),
        .op_ready(op_ready), .res_valid(res_valid), .res_hit(res_hit), .res_err(res_err),
        .res_data(res_data), .res_par(res_par), .flush(flush), .mck_req(mck_req),
        .me(me), .save_pc(save_pc), .save_msr(save_msr), .status(status));

    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = 6'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        m_data[idx] = d; m_vld[idx] = 1;
        for (int g = 0; g < 4; g++) m_par[idx][g] = (^d[g*8 +: 8]) ^ m_inj[g];
    endtask

    task automatic set_inj(input logic [3:0] v);
        @(negedge clk);
        inj_wr_en = 1; inj_val = v;
        @(negedge clk);
        inj_wr_en = 0; m_inj = v;
    endtask

    task automatic me_on();
        @(negedge clk);
        me_set = 1;
        @(negedge clk);
        me_set = 0; m_me = 1;
        check("R7", "me after set", me, 1);
    endtask

    task automatic clr(input logic [6:0] mask);
        @(negedge clk);
        st_clr_en = 1; st_clr_mask = mask;
        @(negedge clk);
        st_clr_en = 0;
        m_st = m_st & ~mask;
        check("R10", "status after clear", status, m_st);
    endtask

    task automatic run_op(input logic [1:0] k, input int idx, input logic [31:0] pc);
        bit v, err, rd, supp, trap, prec;
        logic [3:0] syn;
        string tag;
        v = m_vld[idx];
        syn = 0;
        for (int g = 0; g < 4; g++) if (v) syn[g] = (^m_data[idx][g*8 +: 8]) ^ m_par[idx][g];
        err  = (syn != 0);
        rd   = (k == 2'd0);
        prec = m_me && (!rd || recov_en);
        supp = err && (!rd || prec);
        trap = err && m_me;
        if (!err) tag = v ? "R2" : "R9";
        else if (!rd) tag = "R8";
        else if (!m_me) tag = "R4";
        else tag = recov_en ? "R5" : "R6";

        @(negedge clk);
        op_valid = 1; op_kind = k; op_idx = 6'(idx); op_pc = pc; msr_in = pc[7:0];
        @(negedge clk);
        op_valid = 0;
        check("R11", "ready in lookup", op_ready, 0);
        check(tag, "res_valid", res_valid, !supp);
        check(tag, "flush", flush, supp);
        if (!supp) begin
            check(tag, "res_hit", res_hit, v);
            check(tag, "res_err", res_err, err);
            check(tag, "res_data", res_data, v ? m_data[idx] : 32'h0);
            check(err ? "R3" : tag, "res_par", res_par, v ? m_par[idx] : 4'h0);
        end
        if (err) m_st = m_st | {syn, !prec, 1'b1, 1'b1};
        @(negedge clk);
        check(err ? "R3" : tag, "status", status, m_st);
        check(tag, "mck_req", mck_req, trap);
        if (trap) begin
            check("R7", "me in trap", me, 0);
            check("R7", "save_pc", save_pc, pc);
            check("R7", "save_msr", save_msr, {pc[7:1], 1'b1});
            m_me = 0;
            @(negedge clk);
            check("R7", "mck_req after", mck_req, 0);
        end
        check("R11", "ready after op", op_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_data[i] = 0; m_par[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", "status", status, 0);
        check("R1", "ready", op_ready, 1);
        check("R1", "mck_req", mck_req, 0);
        check("R1", "me", me, 0);
        check("R1", "flush", flush, 0);
        check("R1", "res_valid", res_valid, 0);
        run_op(2'd0, 5, 32'h100);                  // R9 invalid after reset

        for (int i = 0; i < 16; i++) wr(i, (32'(i) * 32'h9E3779B9) ^ 32'h5A5A0F0F);
        wr(16, 32'h0);
        wr(17, 32'hFFFFFFFF);
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 18; i += 3) run_op(2'(k), i, 32'h2000 + 32'(i));  // R2
        run_op(2'd1, 40, 32'h300);                 // R9

        for (int g = 0; g < 4; g++) begin          // R3 each group on each path, R4, R8
            set_inj(4'(1 << g));
            wr(20 + g, 32'hC3A51E77 + 32'(g));
            set_inj(4'h0);
            for (int k = 0; k < 4; k++) begin
                run_op(2'(k), 20 + g, 32'h4000 + 32'(g * 4 + k));
                clr(7'h7F);
            end
        end

        run_op(2'd0, 20, 32'h500);                 // R10 partial clear
        clr(7'h01);
        clr(7'h0A);

        me_on();
        run_op(2'd0, 3, 32'h600);                  // clean read, no trap
        recov_en = 1;
        run_op(2'd0, 20, 32'h610);                 // R5
        me_on();
        recov_en = 0;
        run_op(2'd0, 21, 32'h620);                 // R6
        me_on();
        run_op(2'd1, 22, 32'h630);                 // R8 trap on search
        me_on();
        run_op(2'd2, 23, 32'h640);                 // R8 trap on instruction refill
        me_on();
        run_op(2'd3, 21, 32'h650);                 // R8 trap on data refill
        clr(7'h7F);

        set_inj(4'b1010);                          // R3 two groups
        wr(30, 32'h12345678);
        set_inj(4'h0);
        run_op(2'd0, 30, 32'h700);
        run_op(2'd3, 30, 32'h710);
        wr(20, 32'hC3A51E77);                      // R2 rewrite clean
        run_op(2'd0, 20, 32'h720);
        clr(7'h7F);
        finish_run();
    end
endmodule